// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the control state machine for a dispenser that sells one item priced at 15 cents. A single coin slot takes 5-cent and 10-cent coins. A sensor reports each accepted coin as a one-cycle strobe, with one strobe line for each coin value. The controller keeps the running credit as one of four levels: nothing, 5 cents, 10 cents, and the price reached or passed. In the top level it raises a release output that drives the chute mechanism.

The machine is a Moore machine. Release depends only on the stored credit level, never directly on the coin strobes. Overpayment is not tracked and no change is given, so 20 cents counts the same as exactly 15. After one cycle at the top level the credit falls back to zero whatever the strobes show. A sale therefore produces one release pulse that lasts one cycle.

The coin strobes and the release output are plain control pins. They carry no handshake and no back-pressure. A strobe is consumed in the cycle it is sampled, and the chute mechanism must act on the release pulse in the cycle it is high. Price and coin values are parameters counted in 5-cent units. The defaults give the 2-bit credit codes 00, 01, 10 and 11 for 0, 5, 10 and at least 15 cents.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the credit becomes zero (code 00), and `release_o` is 0 in the following cycle.
- R2: A cycle with `nickel_stb`=1 and `dime_stb`=0 raises the credit by one level (5 cents) at the next edge.
- R3: A cycle with `dime_stb`=1 and `nickel_stb`=0 raises the credit by two levels (10 cents) at the next edge.
- R4: A credit that would reach or pass 15 cents settles at the top level (code 11). Paying 20 cents gives the same result as paying exactly 15.
- R5: Below the top level, a cycle with both strobes at 0 leaves the credit unchanged.
- R6: `release_o` is 1 exactly while the credit is at the top level. It rises in the cycle right after the edge that samples the coin reaching the price, and the strobe values in its own cycle have no effect on it.
- R7: After one cycle at the top level the credit returns to zero unconditionally. A coin strobed during the release cycle is discarded and adds no credit.
- R8: A cycle with both strobes at 1 is illegal. It is treated as no coin and the credit is held.
- R9: Reset has priority over coin strobes sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_stb | input | 1 | One-cycle strobe for a 5-cent coin |
| dime_stb | input | 1 | One-cycle strobe for a 10-cent coin |
| release_o | output | 1 | Chute release, high for one cycle per sale |

## Verification
The only register between the pins is the credit register. A strobe sampled at one rising edge can therefore change `release_o` just after that same edge, and that is the single cycle the bench checks. The bench drives inputs one time unit after a rising edge and samples `release_o` one time unit after the next rising edge, so each check sees the effect of exactly one sampled input set. Levels below the top are seen through the number of further coins needed before release appears. A reference credit counter in the bench predicts release for a directed vector table and for every sequence of up to five coins. Separate directed checks cover reset priority, illegal strobes and a coin arriving during release.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

  // Classification of one sampled cycle of the coin sensor
  typedef enum logic [1:0] {
    COIN_NONE  = 2'b00,
    COIN_SMALL = 2'b01,
    COIN_LARGE = 2'b10,
    COIN_BAD   = 2'b11
  } coin_kind_e;

endpackage

// File: rtl/coin_classify.sv
module coin_classify
  import coin_vend_pkg::*;
(
  input  logic       nickel_stb,
  input  logic       dime_stb,
  output coin_kind_e kind
);

  always_comb begin
    unique case ({dime_stb, nickel_stb})
      2'b01:   kind = COIN_SMALL;
      2'b10:   kind = COIN_LARGE;
      2'b11:   kind = COIN_BAD;
      default: kind = COIN_NONE;
    endcase
  end

endmodule

// File: rtl/credit_step.sv
module credit_step
  import coin_vend_pkg::*;
#(
  parameter int unsigned LEVEL_W     = 2,
  parameter int unsigned TOP_LEVEL   = 3,
  parameter int unsigned SMALL_UNITS = 1,
  parameter int unsigned LARGE_UNITS = 2
) (
  input  logic [LEVEL_W-1:0] level_q,
  input  coin_kind_e         kind,
  output logic [LEVEL_W-1:0] level_d
);

  localparam int unsigned     SUM_W = LEVEL_W + 1;
  localparam logic [SUM_W-1:0] TOP_S = SUM_W'(TOP_LEVEL);
  localparam logic [SUM_W-1:0] SMALL_S = SUM_W'(SMALL_UNITS);
  localparam logic [SUM_W-1:0] LARGE_S = SUM_W'(LARGE_UNITS);

  logic [SUM_W-1:0] add_units;
  logic [SUM_W-1:0] sum;

  always_comb begin
    unique case (kind)
      COIN_SMALL: add_units = SMALL_S;
      COIN_LARGE: add_units = LARGE_S;
      default:    add_units = '0;
    endcase
  end

  assign sum = {1'b0, level_q} + add_units;

  always_comb begin
    if ({1'b0, level_q} == TOP_S) begin
      level_d = '0;
    end else if (sum >= TOP_S) begin
      level_d = TOP_S[LEVEL_W-1:0];
    end else begin
      level_d = sum[LEVEL_W-1:0];
    end
  end

endmodule

// File: rtl/credit_reg.sv
module credit_reg #(
  parameter int unsigned LEVEL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] level_d,
  output logic [LEVEL_W-1:0] level_q
);

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import coin_vend_pkg::*;
#(
  parameter int unsigned PRICE_UNITS  = 3,
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_stb,
  input  logic dime_stb,
  output logic release_o
);

  localparam int unsigned        LEVEL_W = $clog2(PRICE_UNITS + 1);
  localparam logic [LEVEL_W-1:0] TOP_L   = LEVEL_W'(PRICE_UNITS);

  coin_kind_e         kind;
  logic [LEVEL_W-1:0] credit_d;
  logic [LEVEL_W-1:0] credit_q;

  coin_classify u_classify (
    .nickel_stb (nickel_stb),
    .dime_stb   (dime_stb),
    .kind       (kind)
  );

  credit_step #(
    .LEVEL_W     (LEVEL_W),
    .TOP_LEVEL   (PRICE_UNITS),
    .SMALL_UNITS (NICKEL_UNITS),
    .LARGE_UNITS (DIME_UNITS)
  ) u_step (
    .level_q (credit_q),
    .kind    (kind),
    .level_d (credit_d)
  );

  credit_reg #(
    .LEVEL_W (LEVEL_W)
  ) u_reg (
    .clk     (clk),
    .rst     (rst),
    .level_d (credit_d),
    .level_q (credit_q)
  );

  // Moore output: decoded from the stored level only
  assign release_o = (credit_q == TOP_L);

endmodule

// File: rtl/coin_vend_ctrl_chk.sv
module coin_vend_ctrl_chk #(
  parameter int unsigned LEVEL_W      = 2,
  parameter int unsigned PRICE_UNITS  = 3,
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               nickel_stb,
  input logic               dime_stb,
  input logic               release_o,
  input logic [LEVEL_W-1:0] credit
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (credit == '0 && !release_o));

  // R2
  nickel_step_chk: assert property (@(posedge clk) disable iff (rst)
    (nickel_stb && !dime_stb && credit == '0) |=> (credit == LEVEL_W'(NICKEL_UNITS)));

  // R3
  dime_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dime_stb && !nickel_stb && credit == '0) |=> (credit == LEVEL_W'(DIME_UNITS)));

  // R4
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (dime_stb && !nickel_stb && !release_o &&
     (int'(credit) + int'(DIME_UNITS) >= int'(PRICE_UNITS))) |=> release_o);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nickel_stb && !dime_stb && !release_o) |=> $stable(credit));

  // R6
  release_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(release_o) |-> $past(nickel_stb || dime_stb));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    release_o |=> (credit == '0 && !release_o));

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nickel_stb && dime_stb && !release_o) |=> $stable(credit));

endmodule

bind coin_vend_ctrl coin_vend_ctrl_chk #(
  .LEVEL_W      (LEVEL_W),
  .PRICE_UNITS  (PRICE_UNITS),
  .NICKEL_UNITS (NICKEL_UNITS),
  .DIME_UNITS   (DIME_UNITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .nickel_stb (nickel_stb),
  .dime_stb   (dime_stb),
  .release_o  (release_o),
  .credit     (credit_q)
);

// File: tb/coin_vend_ctrl_test.sv
`timescale 1ns/100ps
module coin_vend_ctrl_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel_stb = 1'b0;
  logic dime_stb = 1'b0;
  logic release_o;

  int n_checks = 0;
  int n_fail = 0;
  int mdl = 0;   // reference credit in 5-cent units, 3 means enough

  always #2.5 clk = ~clk;

  coin_vend_ctrl uut (
    .clk        (clk),
    .rst        (rst),
    .nickel_stb (nickel_stb),
    .dime_stb   (dime_stb),
    .release_o  (release_o)
  );

  // entry: {rst, nickel, dime, expected release, requirement number}
  localparam int NV = 22;
  localparam logic [7:0] VEC [NV] = '{
    {4'b1000, 4'd1},  // R1 reset
    {4'b0100, 4'd2},  // R2 5c
    {4'b0100, 4'd2},  // R2 10c
    {4'b0101, 4'd6},  // R6 15c release
    {4'b0000, 4'd7},  // R7 back to zero
    {4'b0010, 4'd3},  // R3 10c
    {4'b0011, 4'd4},  // R4 20c saturates
    {4'b0100, 4'd7},  // R7 coin in release cycle dropped
    {4'b0100, 4'd2},  // R2 5c
    {4'b0000, 4'd5},  // R5 hold
    {4'b0000, 4'd5},  // R5 hold
    {4'b0011, 4'd3},  // R3 15c
    {4'b0010, 4'd7},  // R7 dime dropped
    {4'b0110, 4'd8},  // R8 illegal at 0
    {4'b0010, 4'd3},  // R3 10c
    {4'b0110, 4'd8},  // R8 illegal at 10c
    {4'b0101, 4'd2},  // R2 15c
    {4'b0100, 4'd7},  // R7 dropped
    {4'b0010, 4'd3},  // R3 10c
    {4'b1100, 4'd9},  // R9 reset beats nickel
    {4'b0010, 4'd9},  // R9 credit was zero: 10c
    {4'b0101, 4'd9}   // R9 15c
  };

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: release_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, advance the reference model
  task automatic drive(logic r, logic n, logic d);
    rst = r; nickel_stb = n; dime_stb = d;
    @(posedge clk);
    #1;
    if (r) mdl = 0;
    else if (mdl >= 3) mdl = 0;
    else if (n && !d) mdl = (mdl + 1 >= 3) ? 3 : mdl + 1;
    else if (d && !n) mdl = (mdl + 2 >= 3) ? 3 : mdl + 2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    drive(1'b1, 1'b0, 1'b0);
    check("R1", release_o, 1'b0);
    drive(1'b1, 1'b0, 1'b1);
    check("R1", release_o, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][7], VEC[i][6], VEC[i][5]);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), release_o, VEC[i][4]);
      check($sformatf("R%0d model %0d", VEC[i][3:0], i), release_o, (mdl == 3));
    end

    // every nickel/dime sequence of one to five coins (R2 R3 R4 R6 R7)
    for (int len = 1; len <= 5; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        drive(1'b1, 1'b0, 1'b0);
        for (int k = 0; k < len; k++) begin
          drive(1'b0, !pat[k], pat[k]);
          check("R2 R3 R4 R6 R7 sequence", release_o, (mdl == 3));
        end
        drive(1'b0, 1'b0, 1'b0);
        check("R5 R7 sequence tail", release_o, (mdl == 3));
      end
    end

    // R8: illegal strobes at 5c then a nickel lands at 10c, no release
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    check("R8", release_o, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    check("R8", release_o, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    check("R8", release_o, 1'b1);

    // R9: reset with a dime at 10c must not release
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 1'b1);
    check("R9", release_o, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    check("R9", release_o, 1'b0);

    // R7: coin during release adds nothing, then 10c more is not enough
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b1);
    check("R7", release_o, 1'b1);
    drive(1'b0, 1'b0, 1'b1);
    check("R7", release_o, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    check("R7", release_o, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    check("R5", release_o, 1'b0);

    finish_run();
  end

endmodule